// File: doc/BRIEF.md
# Control-Flow Resolution Unit

This single-cycle functional unit settles the outcome of conditional branches, calls and returns in a small 16-bit out-of-order core. Its reservation station hands it an operation once all operands are ready. It compares the two operands of a branch-if-not-equal and forms the address the program continues at. For a call it also produces the return link bound for register R1. The front end always guesses the sequential path, so the unit reports whether that guess was wrong. The issue logic can then redirect fetch and discard what it issued behind the guess.

An operation is presented for one cycle with `valid_i` high, along with the program counter, two operand values and a 6-bit signed displacement. On the next cycle the unit raises a one-cycle completion strobe together with the redirect flag, the resolved next address and, for calls, a link write. Two running counters track how many control-flow operations have resolved and how many of them left the guessed path. A return receives the current value of R1 on its first operand.

Top module: `ctrl_resolve_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `done_o`, `redirect_o` and `link_we_o` are 0 and both counters read 0.
- R2: The operation code on `op_i` is 2'b00 for branch-if-not-equal, 2'b01 for call and 2'b10 for return. Code 2'b11, or any cycle with `valid_i` low, is ignored: no strobe and no counter change follow.
- R3: An accepted operation raises `done_o` on the cycle after the edge that samples it. The strobe stays high for one cycle only, unless another operation is accepted on the next edge.
- R4: A branch with `opa_i != opb_i` is taken. It gives `redirect_o` = 1 and `target_o` = pc + 1 + sign-extended offset, modulo 2^16.
- R5: A branch with equal operands gives `redirect_o` = 0 and `target_o` = pc + 1.
- R6: A call gives `redirect_o` = 1 and `target_o` = pc + 1 + sign-extended offset, modulo 2^16. It also gives `link_we_o` = 1 and `link_o` = pc + 1. No other operation raises `link_we_o`.
- R7: A return gives `redirect_o` = 1 and `target_o` = `opa_i` (the R1 value), whatever the offset and `opb_i` hold.
- R8: The offset is a 6-bit two's-complement value in -32..31. Bit 5 is the sign bit, and sums wrap around the 16-bit address space.
- R9: `branch_cnt_o` rises by one with every strobe. `mispred_cnt_o` rises by one with every strobe that carries `redirect_o` = 1. Both new counts are visible in the strobe cycle.
- R10: Both counters wrap to zero after 2^CNTW - 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 2 | Operation code |
| pc_i | input | XLEN | Address of the operation |
| opa_i | input | XLEN | First operand (R1 for return) |
| opb_i | input | XLEN | Second operand |
| off_i | input | OFFW | Signed displacement |
| done_o | output | 1 | One-cycle resolve strobe |
| redirect_o | output | 1 | Sequential guess was wrong |
| target_o | output | XLEN | Resolved next address |
| link_we_o | output | 1 | Write `link_o` to R1 |
| link_o | output | XLEN | Return link, pc + 1 |
| branch_cnt_o | output | CNTW | Resolved operation count |
| mispred_cnt_o | output | CNTW | Redirect count |

## Verification
The bench keeps XLEN at 16 and OFFW at 6, so address wrap at 0xFFFF and both ends of the displacement range are exercised exactly as the core would see them. It narrows CNTW to 4. That way both counters pass their rollover within a few dozen operations, which makes the wrap requirement observable in a short run.

// File: rtl/ctrl_resolve_unit.sv
module ctrl_resolve_unit #(
  parameter int XLEN = 16,
  parameter int OFFW = 6,
  parameter int CNTW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_i,
  input  logic [1:0]      op_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  input  logic [OFFW-1:0] off_i,
  output logic            done_o,
  output logic            redirect_o,
  output logic [XLEN-1:0] target_o,
  output logic            link_we_o,
  output logic [XLEN-1:0] link_o,
  output logic [CNTW-1:0] branch_cnt_o,
  output logic [CNTW-1:0] mispred_cnt_o
);

  localparam logic [1:0] OP_BNE  = 2'b00;
  localparam logic [1:0] OP_CALL = 2'b01;
  localparam logic [1:0] OP_RET  = 2'b10;
  localparam int         EXTW    = XLEN - OFFW;

  logic            is_bne, is_call, is_ret, accept, differ, taken;
  logic [XLEN-1:0] seq_pc, rel_pc, next_pc;

  assign is_bne  = (op_i == OP_BNE);
  assign is_call = (op_i == OP_CALL);
  assign is_ret  = (op_i == OP_RET);
  assign accept  = valid_i && (is_bne || is_call || is_ret);

  assign differ  = (opa_i != opb_i);
  assign taken   = !is_bne || differ;

  assign seq_pc  = pc_i + XLEN'(1);
  assign rel_pc  = seq_pc + {{EXTW{off_i[OFFW-1]}}, off_i};
  assign next_pc = is_ret ? opa_i : (taken ? rel_pc : seq_pc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o        <= 1'b0;
      redirect_o    <= 1'b0;
      target_o      <= '0;
      link_we_o     <= 1'b0;
      link_o        <= '0;
      branch_cnt_o  <= '0;
      mispred_cnt_o <= '0;
    end else begin
      done_o <= accept;
      if (accept) begin
        redirect_o   <= taken;
        target_o     <= next_pc;
        link_we_o    <= is_call;
        link_o       <= seq_pc;
        branch_cnt_o <= branch_cnt_o + CNTW'(1);
        if (taken) mispred_cnt_o <= mispred_cnt_o + CNTW'(1);
      end else begin
        redirect_o <= 1'b0;
        link_we_o  <= 1'b0;
      end
    end
  end

  // R2 / R3: strobe follows an accepted code only
  a_r2_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 2'b11) |=> !done_o);
  a_r3_strobe_latency: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !done_o);

  // R6: link write only with a redirecting strobe of a call
  a_r6_link_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    link_we_o |-> (done_o && redirect_o));
  a_r6_link_value: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == OP_CALL) |=> (link_we_o && link_o == $past(pc_i) + XLEN'(1)));

  // R7: return jumps through the first operand
  a_r7_ret_target: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == OP_RET) |=> (redirect_o && target_o == $past(opa_i)));

  // R9: counters move only with the strobe
  a_r9_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(branch_cnt_o) && $stable(mispred_cnt_o)));
  a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (branch_cnt_o == $past(branch_cnt_o) + CNTW'(1)));
  a_r9_redirect_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> done_o);

endmodule

// File: tb/ctrl_resolve_unit_tb_top.sv
module ctrl_resolve_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 16;
  localparam int OFFW = 6;
  localparam int CNTW = 4;
  localparam int NVEC = 11;

  // {op, pc, a, b, off}
  localparam logic [55:0] VECS [0:NVEC-1] = '{
    {2'b00, 16'h0010, 16'h0005, 16'h0007, 6'd3},
    {2'b00, 16'h0010, 16'h0005, 16'h0005, 6'd3},
    {2'b00, 16'h0040, 16'h0001, 16'h0002, 6'h20},
    {2'b00, 16'h0000, 16'h0000, 16'h0001, 6'h3F},
    {2'b00, 16'hFFFF, 16'h0003, 16'h0004, 6'd31},
    {2'b01, 16'h0100, 16'h0000, 16'h0000, 6'd5},
    {2'b01, 16'h0002, 16'h0000, 16'h0000, 6'h38},
    {2'b10, 16'h0200, 16'h1234, 16'h0009, 6'h15},
    {2'b00, 16'hFFFE, 16'h0000, 16'h0000, 6'd7},
    {2'b01, 16'hFFFF, 16'h0000, 16'h0000, 6'd0},
    {2'b10, 16'h7000, 16'h0000, 16'hFFFF, 6'h3F}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0;
  logic [1:0] op_i = '0;
  logic [XLEN-1:0] pc_i = '0, opa_i = '0, opb_i = '0;
  logic [OFFW-1:0] off_i = '0;
  logic done_o, redirect_o, link_we_o;
  logic [XLEN-1:0] target_o, link_o;
  logic [CNTW-1:0] branch_cnt_o, mispred_cnt_o;

  int n_chk = 0, n_fail = 0;
  int m_br = 0, m_mp = 0;
  bit finished = 1'b0;

  ctrl_resolve_unit #(.XLEN(XLEN), .OFFW(OFFW), .CNTW(CNTW)) dut_i (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .pc_i(pc_i),
    .opa_i(opa_i), .opb_i(opb_i), .off_i(off_i), .done_o(done_o),
    .redirect_o(redirect_o), .target_o(target_o), .link_we_o(link_we_o),
    .link_o(link_o), .branch_cnt_o(branch_cnt_o), .mispred_cnt_o(mispred_cnt_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  // Called at a negedge; returns at the negedge after the sampling edge.
  task automatic run_op(input logic [1:0] op, input logic [15:0] pc, input logic [15:0] a,
                        input logic [15:0] b, input logic [5:0] off);
    logic [15:0] seq, rel, exp_t;
    logic exp_r;
    seq = pc + 16'd1;
    rel = seq + {{10{off[5]}}, off};
    exp_r = (op != 2'b00) || (a != b);
    exp_t = (op == 2'b10) ? a : (exp_r ? rel : seq);
    valid_i = 1'b1; op_i = op; pc_i = pc; opa_i = a; opb_i = b; off_i = off;
    @(negedge clk);
    valid_i = 1'b0;
    if (op != 2'b11) begin
      m_br++;
      if (exp_r) m_mp++;
      chk("R3 done", 32'(done_o), 32'd1);
      chk(op == 2'b00 ? (exp_r ? "R4 redirect" : "R5 redirect") :
          (op == 2'b01 ? "R6 redirect" : "R7 redirect"), 32'(redirect_o), 32'(exp_r));
      chk(op == 2'b00 ? (exp_r ? "R4/R8 target" : "R5 target") :
          (op == 2'b01 ? "R6/R8 target" : "R7 target"), 32'(target_o), 32'(exp_t));
      chk("R6 link_we", 32'(link_we_o), 32'(op == 2'b01));
      if (op == 2'b01) chk("R6 link", 32'(link_o), 32'(seq));
    end else begin
      chk("R2 reserved no strobe", 32'(done_o), 32'd0);
    end
    chk("R9/R10 branch count", 32'(branch_cnt_o), 32'(m_br % (1 << CNTW)));
    chk("R9/R10 mispredict count", 32'(mispred_cnt_o), 32'(m_mp % (1 << CNTW)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 done in reset", 32'(done_o), 32'd0);
    chk("R1 redirect in reset", 32'(redirect_o), 32'd0);
    chk("R1 count in reset", 32'(branch_cnt_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 link_we after reset", 32'(link_we_o), 32'd0);
    chk("R1 mispredict count after reset", 32'(mispred_cnt_o), 32'd0);

    for (int i = 0; i < NVEC; i++)
      run_op(VECS[i][55:54], VECS[i][53:38], VECS[i][37:22], VECS[i][21:6], VECS[i][5:0]);

    // R3: single pulse when no follow-up
    @(negedge clk);
    chk("R3 strobe one cycle", 32'(done_o), 32'd0);
    chk("R3 redirect drops", 32'(redirect_o), 32'd0);

    // R2: reserved code ignored, counters held
    run_op(2'b11, 16'h0050, 16'h0001, 16'h0002, 6'd4);
    chk("R2 reserved no redirect", 32'(redirect_o), 32'd0);

    // R2: valid low with branch code ignored
    op_i = 2'b00; opa_i = 16'h1; opb_i = 16'h2; valid_i = 1'b0;
    @(negedge clk);
    chk("R2 invalid no strobe", 32'(done_o), 32'd0);
    chk("R2 invalid count held", 32'(branch_cnt_o), 32'(m_br % (1 << CNTW)));

    // R3: back-to-back operations keep the strobe high
    run_op(2'b00, 16'h0300, 16'h0004, 16'h0004, 6'd2);
    run_op(2'b01, 16'h0301, 16'h0000, 16'h0000, 6'h3E);

    // R10: drive both counters past wrap with taken branches
    for (int k = 0; k < 20; k++)
      run_op(2'b00, 16'(k * 7), 16'(k), 16'(k + 1), 6'(k));
    chk("R10 branch count wrapped", 32'(m_br >= (1 << CNTW)), 32'd1);
    chk("R10 mispredict count wrapped", 32'(m_mp >= (1 << CNTW)), 32'd1);

    @(negedge clk);
    summary();
  end
endmodule